// File: doc/BRIEF.md
# Page Overflow Predictor

The block decides, at each writeback to a compressed page, whether that page should be grown at once to its full 4KB size and kept uncompressed. Such pages are being filled with incompressible data line by line. Without this step they would overflow once for each page size on the way up. Every metadata cache entry owns a 2-bit saturating counter that tracks line overflows and underflows of its page. A single 3-bit saturating counter follows page overflow behaviour across the whole system. A page is inflated only when the top bits of both counters are set.

The metadata cache tells the block when an entry is filled and when it is evicted. The write path reports each writeback with the entry index and two flags, one for a line overflow and one for a line underflow. It also reports each page-level size event, marked as an overflow or not. One cycle after each accepted writeback the block presents a registered decision: a valid flag and the inflate bit.

Top module: `pg_ovf_pred`

## Requirements
- R1: While reset is asserted and after it is released, both outputs are 0, every entry is invalid, and the global counter is 0.
- R2: An accepted writeback that reports a line overflow without an underflow raises its entry's local counter by one, and the counter stays at 3 once it is there.
- R3: An accepted writeback that reports a line underflow without an overflow lowers its entry's local counter by one, and the counter stays at 0 once it is there.
- R4: An accepted writeback that reports both an overflow and an underflow leaves the local counter unchanged.
- R5: A page event raises the global counter by one when `pg_ovf_i` is 1 and lowers it by one when `pg_ovf_i` is 0. The counter saturates at 7 and at 0, and it holds when no page event is present.
- R6: In the cycle after an accepted writeback, `inflate_o` is 1 exactly when bit 1 of that entry's updated local counter and bit 2 of the updated global counter are both 1. Both counters are taken after all updates of the writeback's cycle, including a page event in that same cycle.
- R7: A fill makes the entry valid and sets its local counter to 0.
- R8: An eviction makes the entry invalid. A writeback to an invalid entry is ignored: no decision is produced and no counter changes.
- R9: A fill or an eviction of the same index in the same cycle as a writeback takes priority, and the writeback is ignored. A fill and an eviction of the same index in one cycle leave the entry valid with a counter of 0.
- R10: `dec_vld_o` is 1 exactly in the cycle after an accepted writeback, whether or not an overflow or underflow was reported. When `dec_vld_o` is 0, `inflate_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_i | input | 1 | Metadata cache fill of an entry |
| fill_idx_i | input | IDX_W | Index of the entry being filled |
| evict_i | input | 1 | Metadata cache eviction of an entry |
| evict_idx_i | input | IDX_W | Index of the entry being evicted |
| wb_i | input | 1 | Writeback to a page |
| wb_idx_i | input | IDX_W | Entry index of the written page |
| line_ovf_i | input | 1 | The written line grew past its slot |
| line_unf_i | input | 1 | The written line became more compressible |
| pg_evt_i | input | 1 | Page-level size event |
| pg_ovf_i | input | 1 | The page event is an overflow |
| dec_vld_o | output | 1 | Decision valid, one cycle after an accepted writeback |
| inflate_o | output | 1 | Grow the page to full size and store it uncompressed |

## Verification
An internal state error shows up only through the inflate bit. A local counter that wraps, or that is not cleared on fill, makes the inflate bit flip on a later writeback to that entry. This is visible as soon as the counter's top bit differs from the value that saturation rules give, often several writebacks after the fault. A wrapped global counter shows the same way, but only when a writeback arrives while the local top bit is set. The tests therefore drive counters past both limits and then step back across the top-bit threshold. A valid bit that is wrong is seen in the very next cycle as a missing or extra decision.

// File: rtl/pop_pkg.sv
package pop_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_CLR  = 2'd3
  } ctr_op_e;

  function automatic ctr_op_e pick_op(input logic clr, input logic up, input logic down);
    if (clr)              return OP_CLR;
    else if (up && !down) return OP_UP;
    else if (down && !up) return OP_DOWN;
    else                  return OP_HOLD;
  endfunction
endpackage

// File: rtl/pop_sat_ctr.sv
module pop_sat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         up_i,
  input  logic         down_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  import pop_pkg::*;

  localparam logic [W-1:0] MAX = {W{1'b1}};

  ctr_op_e     op;
  logic [W-1:0] q;

  always_comb begin
    op    = pick_op(clr_i, up_i, down_i);
    nxt_o = q;
    unique case (op)
      OP_CLR:  nxt_o = '0;
      OP_UP:   if (q != MAX) nxt_o = q + 1'b1;
      OP_DOWN: if (q != '0)  nxt_o = q - 1'b1;
      default: nxt_o = q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/pop_local_bank.sv
module pop_local_bank #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned LCL_W     = 2,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             evict_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  input  logic             wb_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic             line_ovf_i,
  input  logic             line_unf_i,
  output logic             hit_o,
  output logic [LCL_W-1:0] sel_q_o,
  output logic [LCL_W-1:0] sel_nxt_o
);
  logic [N_ENTRIES-1:0] vld_q;
  logic [LCL_W-1:0]     loc_q   [N_ENTRIES];
  logic [LCL_W-1:0]     loc_nxt [N_ENTRIES];
  logic                 wb_blocked;

  // fill/evict on the written index wins over the writeback
  assign wb_blocked = (fill_i && fill_idx_i == wb_idx_i) ||
                      (evict_i && evict_idx_i == wb_idx_i);
  assign hit_o      = wb_i && vld_q[wb_idx_i] && !wb_blocked;
  assign sel_q_o    = loc_q[wb_idx_i];
  assign sel_nxt_o  = loc_nxt[wb_idx_i];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic fill_me, evict_me, wb_me;

    assign fill_me  = fill_i  && fill_idx_i  == IDX_W'(i);
    assign evict_me = evict_i && evict_idx_i == IDX_W'(i);
    assign wb_me    = hit_o   && wb_idx_i    == IDX_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       vld_q[i] <= 1'b0;
      else if (fill_me)  vld_q[i] <= 1'b1;
      else if (evict_me) vld_q[i] <= 1'b0;
    end

    pop_sat_ctr #(.W(LCL_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (fill_me || evict_me),
      .up_i   (wb_me && line_ovf_i),
      .down_i (wb_me && line_unf_i),
      .q_o    (loc_q[i]),
      .nxt_o  (loc_nxt[i])
    );
  end
endmodule

// File: rtl/pg_ovf_pred.sv
module pg_ovf_pred #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned LCL_W     = 2,
  parameter int unsigned GLB_W     = 3,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             evict_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  input  logic             wb_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic             line_ovf_i,
  input  logic             line_unf_i,
  input  logic             pg_evt_i,
  input  logic             pg_ovf_i,
  output logic             dec_vld_o,
  output logic             inflate_o
);
  logic             hit;
  logic [LCL_W-1:0] loc_q, loc_nxt;
  logic [GLB_W-1:0] glb_q, glb_nxt;
  logic             dec_vld_q, inflate_q;

  pop_local_bank #(
    .N_ENTRIES (N_ENTRIES),
    .LCL_W     (LCL_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill_i),
    .fill_idx_i  (fill_idx_i),
    .evict_i     (evict_i),
    .evict_idx_i (evict_idx_i),
    .wb_i        (wb_i),
    .wb_idx_i    (wb_idx_i),
    .line_ovf_i  (line_ovf_i),
    .line_unf_i  (line_unf_i),
    .hit_o       (hit),
    .sel_q_o     (loc_q),
    .sel_nxt_o   (loc_nxt)
  );

  pop_sat_ctr #(.W(GLB_W)) u_glb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .up_i   (pg_evt_i && pg_ovf_i),
    .down_i (pg_evt_i && !pg_ovf_i),
    .q_o    (glb_q),
    .nxt_o  (glb_nxt)
  );

  // decision uses post-update counter state of this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_q <= 1'b0;
      inflate_q <= 1'b0;
    end else begin
      dec_vld_q <= hit;
      inflate_q <= hit && loc_nxt[LCL_W-1] && glb_nxt[GLB_W-1];
    end
  end

  assign dec_vld_o = dec_vld_q;
  assign inflate_o = inflate_q;
endmodule

// File: rtl/pop_chk.sv
module pop_chk #(
  parameter int unsigned LCL_W = 2,
  parameter int unsigned GLB_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wb_i,
  input logic             line_ovf_i,
  input logic             line_unf_i,
  input logic             pg_evt_i,
  input logic             pg_ovf_i,
  input logic             dec_vld_o,
  input logic             inflate_o,
  input logic             hit,
  input logic [LCL_W-1:0] loc_q,
  input logic [LCL_W-1:0] loc_nxt,
  input logic [GLB_W-1:0] glb_q
);
  localparam logic [LCL_W-1:0] LMAX = {LCL_W{1'b1}};
  localparam logic [GLB_W-1:0] GMAX = {GLB_W{1'b1}};

  a_r10_vld_needs_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(wb_i));

  a_r10_no_inflate_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflate_o |-> dec_vld_o);

  a_r6_inflate_needs_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflate_o |-> glb_q[GLB_W-1]);

  a_r5_glb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_evt_i |=> $stable(glb_q));

  a_r5_glb_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_evt_i && pg_ovf_i && glb_q == GMAX) |=> glb_q == GMAX);

  a_r5_glb_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_evt_i && !pg_ovf_i && glb_q == '0) |=> glb_q == '0);

  a_r2_loc_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && line_ovf_i && !line_unf_i && loc_q == LMAX) |-> loc_nxt == LMAX);

  a_r3_loc_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && line_unf_i && !line_ovf_i && loc_q == '0) |-> loc_nxt == '0);

  a_r4_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && line_ovf_i && line_unf_i) |-> loc_nxt == loc_q);
endmodule

bind pg_ovf_pred pop_chk #(
  .LCL_W (LCL_W),
  .GLB_W (GLB_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_i       (wb_i),
  .line_ovf_i (line_ovf_i),
  .line_unf_i (line_unf_i),
  .pg_evt_i   (pg_evt_i),
  .pg_ovf_i   (pg_ovf_i),
  .dec_vld_o  (dec_vld_o),
  .inflate_o  (inflate_o),
  .hit        (hit),
  .loc_q      (loc_q),
  .loc_nxt    (loc_nxt),
  .glb_q      (glb_q)
);

// File: tb/pg_ovf_pred_tb.sv
`timescale 1ns/1ps
module pg_ovf_pred_tb;
  localparam int unsigned N_ENTRIES = 16;
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fill_i = 1'b0, evict_i = 1'b0, wb_i = 1'b0;
  logic [IDX_W-1:0] fill_idx_i = '0, evict_idx_i = '0, wb_idx_i = '0;
  logic             line_ovf_i = 1'b0, line_unf_i = 1'b0;
  logic             pg_evt_i = 1'b0, pg_ovf_i = 1'b0;
  logic             dec_vld_o, inflate_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  pg_ovf_pred #(.N_ENTRIES(N_ENTRIES)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill_i),
    .fill_idx_i  (fill_idx_i),
    .evict_i     (evict_i),
    .evict_idx_i (evict_idx_i),
    .wb_i        (wb_i),
    .wb_idx_i    (wb_idx_i),
    .line_ovf_i  (line_ovf_i),
    .line_unf_i  (line_unf_i),
    .pg_evt_i    (pg_evt_i),
    .pg_ovf_i    (pg_ovf_i),
    .dec_vld_o   (dec_vld_o),
    .inflate_o   (inflate_o)
  );

  task automatic check(input string req, input logic act_v, input logic act_i,
                       input logic exp_v, input logic exp_i);
    n_chk++;
    if (act_v !== exp_v || act_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s: vld/inflate actual %b%b expected %b%b", req, act_v, act_i, exp_v, exp_i);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    fill_i = 0; evict_i = 0; wb_i = 0; line_ovf_i = 0; line_unf_i = 0;
    pg_evt_i = 0; pg_ovf_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    @(posedge clk_i);
    #1;
    check("R1 in reset", dec_vld_o, inflate_o, 0, 0);
    rst_ni = 1;
  endtask

  task automatic do_fill(input int idx);
    fill_i = 1; fill_idx_i = IDX_W'(idx);
    tick();
  endtask

  task automatic do_evict(input int idx);
    evict_i = 1; evict_idx_i = IDX_W'(idx);
    tick();
  endtask

  task automatic do_pg(input logic ovf, input int n);
    for (int k = 0; k < n; k++) begin
      pg_evt_i = 1; pg_ovf_i = ovf;
      tick();
    end
  endtask

  // writeback, then check the registered decision at the following edge
  task automatic do_wb(input int idx, input logic ovf, input logic unf,
                       input logic ev, input logic ei, input string req);
    wb_i = 1; wb_idx_i = IDX_W'(idx); line_ovf_i = ovf; line_unf_i = unf;
    @(posedge clk_i);
    #1;
    check(req, dec_vld_o, inflate_o, ev, ei);
    fill_i = 0; evict_i = 0; wb_i = 0; line_ovf_i = 0; line_unf_i = 0;
    pg_evt_i = 0; pg_ovf_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after release", dec_vld_o, inflate_o, 0, 0);
    do_pg(1, 4);
    do_wb(0, 1, 0, 0, 0, "R1 entries start invalid");
  endtask

  task automatic t_local_up_down();
    do_reset();
    do_fill(3);
    do_pg(1, 4);
    do_wb(3, 1, 0, 1, 0, "R2 local 0->1");
    do_wb(3, 1, 0, 1, 1, "R2 R6 local 1->2 inflate");
    tick();
    check("R6 R10 idle after decision", dec_vld_o, inflate_o, 0, 0);
    do_wb(3, 1, 0, 1, 1, "R2 local 2->3");
    do_wb(3, 1, 0, 1, 1, "R2 local holds 3");
    do_wb(3, 0, 1, 1, 1, "R2 saturation then 3->2");
    do_wb(3, 0, 1, 1, 0, "R3 local 2->1");
    do_wb(3, 0, 1, 1, 0, "R3 local 1->0");
    do_wb(3, 0, 1, 1, 0, "R3 local holds 0");
    do_wb(3, 1, 0, 1, 0, "R3 saturation then 0->1");
    do_wb(3, 1, 0, 1, 1, "R3 local 1->2");
    do_wb(3, 0, 0, 1, 1, "R10 decision with no flag");
  endtask

  task automatic t_cancel();
    do_reset();
    do_fill(5);
    do_pg(1, 4);
    do_wb(5, 1, 0, 1, 0, "R4 setup");
    do_wb(5, 1, 1, 1, 0, "R4 cancel at 1");
    do_wb(5, 1, 0, 1, 1, "R4 1->2 after cancel");
    do_wb(5, 1, 1, 1, 1, "R4 cancel at 2");
    do_wb(5, 0, 1, 1, 0, "R4 2->1 after cancel");
  endtask

  task automatic t_global();
    do_reset();
    do_fill(1);
    do_wb(1, 1, 0, 1, 0, "R5 setup");
    do_wb(1, 1, 0, 1, 0, "R5 global 0 blocks");
    do_pg(1, 3);
    do_wb(1, 0, 0, 1, 0, "R5 global 3");
    do_pg(1, 1);
    do_wb(1, 0, 0, 1, 1, "R5 global 4");
    do_pg(1, 5);
    do_pg(0, 3);
    do_wb(1, 0, 0, 1, 1, "R5 saturated 7 then 4");
    do_pg(0, 1);
    do_wb(1, 0, 0, 1, 0, "R5 down to 3");
    do_pg(0, 5);
    do_pg(1, 4);
    do_wb(1, 0, 0, 1, 1, "R5 floor 0 then 4");
    do_pg(0, 1);
    pg_evt_i = 1; pg_ovf_i = 1;
    do_wb(1, 0, 0, 1, 1, "R6 same-cycle page overflow counted");
    pg_evt_i = 1; pg_ovf_i = 0;
    do_wb(1, 0, 0, 1, 0, "R6 same-cycle page event lowers");
  endtask

  task automatic t_fill_evict();
    do_reset();
    do_pg(1, 4);
    do_fill(2);
    do_wb(2, 1, 0, 1, 0, "R7 counter starts 0");
    do_wb(2, 1, 0, 1, 1, "R7 reach 2");
    do_evict(2);
    do_wb(2, 1, 0, 0, 0, "R8 evicted entry ignored");
    do_wb(2, 0, 1, 0, 0, "R8 evicted entry ignored unf");
    do_fill(2);
    do_wb(2, 1, 0, 1, 0, "R7 refill clears counter");
    do_fill(9);
    do_wb(9, 1, 0, 1, 0, "R8 other entry independent");
    do_wb(2, 1, 0, 1, 1, "R8 entry 2 unaffected by 9");
  endtask

  task automatic t_collide();
    do_reset();
    do_pg(1, 4);
    do_fill(4);
    do_wb(4, 1, 0, 1, 0, "R9 setup");
    do_wb(4, 1, 0, 1, 1, "R9 setup 2");
    fill_i = 1; fill_idx_i = 4;
    do_wb(4, 1, 0, 0, 0, "R9 fill beats writeback");
    do_wb(4, 1, 0, 1, 0, "R9 counter cleared, wb not counted");
    do_wb(4, 1, 0, 1, 1, "R9 reach 2");
    evict_i = 1; evict_idx_i = 4;
    do_wb(4, 0, 1, 0, 0, "R9 evict beats writeback");
    do_wb(4, 1, 0, 0, 0, "R9 entry invalid after evict");
    fill_i = 1; fill_idx_i = 4; evict_i = 1; evict_idx_i = 4;
    tick();
    do_wb(4, 1, 0, 1, 0, "R9 fill+evict leaves valid at 0");
    fill_i = 1; fill_idx_i = 7;
    do_wb(4, 1, 0, 1, 1, "R9 fill of other index does not block");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_local_up_down();
    t_cancel();
    t_global();
    t_fill_evict();
    t_collide();
    repeat (2) @(posedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule